// File: doc/BRIEF.md
# Local Alignment Scoring Array

This block scores a local alignment between a short query sequence and a streamed database sequence. It is built as a chain of identical processing elements. Each element keeps one query symbol and produces one row of the scoring matrix. Database symbols enter the first element one per valid cycle. Each symbol moves one element further down the chain on every valid cycle. Every element therefore fills one matrix cell per cycle, working only from values held by itself and its upstream neighbour. No element reads any external memory while scoring.

The query is written before a run, one symbol at a time, by element index. Match, mismatch and gap weights are inputs, and software holds them steady for the whole run. A first-symbol marker travels with the data and restarts the matrix boundaries, so sequences can follow each other with no gap between them. The chain also carries a running maximum. When the last symbol of a sequence leaves the final element, the best cell score for that sequence comes out together with a last-symbol flag.

Top module: `lsa_array`

## Requirements
- R1: A write with `qry_we_i` high stores `qry_char_i` in the element at `qry_idx_i`. Element k scores query row k+1. Indices at or above the element count are not allowed.
- R2: Each cell score is the largest of four values: zero, the diagonal cell plus the substitution score, the cell above minus `gap_i`, and the cell to the left minus `gap_i`. The substitution score is +`match_i` when the symbols are equal and -`mismatch_i` when they differ.
- R3: A cycle with `in_first_i` high starts a new sequence. Every boundary cell is treated as zero, and earlier sequences have no effect on the new result, even when there is no idle cycle between the two sequences.
- R4: `out_last_o` pulses exactly NUM_PE clock cycles after the cycle that accepted the symbol marked `in_last_i`. In that cycle `best_o` holds the largest cell score over the whole matrix of that sequence.
- R5: Cycles with `in_valid_i` low change no element state. Idle cycles placed between symbols leave the final score unchanged, and `best_o` holds its value while `out_valid_o` is low.
- R6: While `rst_ni` is low, `out_valid_o` is low and `best_o` is zero.
- R7: Cell scores never drop below zero. A database sequence that shares no symbol with the query gives a best score of 0.
- R8: `out_valid_o` gives exactly one pulse for each accepted input symbol. At no time are more than NUM_PE symbols in flight.
- R9: The all-ones symbol code is a pad. It matches no symbol, not even another pad. Pad symbols fill the elements that lie past the end of a shorter query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| qry_we_i | input | 1 | Query symbol write strobe |
| qry_idx_i | input | $clog2(NUM_PE) | Element selected for the query write |
| qry_char_i | input | CHAR_W | Query symbol to store |
| match_i | input | PEN_W | Score added on a symbol match |
| mismatch_i | input | PEN_W | Score subtracted on a symbol mismatch |
| gap_i | input | PEN_W | Linear gap penalty |
| in_valid_i | input | 1 | Database symbol valid |
| in_first_i | input | 1 | First symbol of a database sequence |
| in_last_i | input | 1 | Last symbol of a database sequence |
| in_char_i | input | CHAR_W | Database symbol |
| out_valid_o | output | 1 | A symbol has left the final element |
| out_last_o | output | 1 | The last symbol of a sequence has left the final element |
| best_o | output | SCORE_W | Running best score of the current sequence |

## Verification
The bench compares each result against a full-matrix model. It uses random query and database pairs over a four-symbol alphabet, with query lengths that vary so that pad rows appear, and two different weight sets. A single stored symbol against a one-symbol database shows that the index write lands in the right row. A database that shares no symbol with the query tests the zero floor. Random idle cycles placed between symbols test whether invalid cycles really leave state alone. Two sequences sent back to back, with no idle cycle between them, show whether the first-symbol marker clears the boundaries. Counting cycles to the last-symbol pulse, and counting output pulses, checks the latency and the one-for-one transfer of symbols.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int unsigned SCORE_W_DEF = 24;
  localparam int unsigned CHAR_W_DEF  = 5;
  localparam int unsigned PEN_W_DEF   = 8;
  localparam int unsigned NUM_PE_DEF  = 48;
endpackage

// File: rtl/lsa_cell.sv
module lsa_cell #(
  parameter int unsigned SCORE_W = lsa_pkg::SCORE_W_DEF,
  parameter int unsigned CHAR_W  = lsa_pkg::CHAR_W_DEF,
  parameter int unsigned PEN_W   = lsa_pkg::PEN_W_DEF
) (
  input  logic [CHAR_W-1:0]  qch_i,
  input  logic [CHAR_W-1:0]  dch_i,
  input  logic [SCORE_W-1:0] diag_i,
  input  logic [SCORE_W-1:0] up_i,
  input  logic [SCORE_W-1:0] left_i,
  input  logic [PEN_W-1:0]   match_i,
  input  logic [PEN_W-1:0]   mismatch_i,
  input  logic [PEN_W-1:0]   gap_i,
  output logic [SCORE_W-1:0] h_o
);
  localparam int unsigned EW = SCORE_W + 2;
  localparam logic [CHAR_W-1:0] PAD = '1;

  logic signed [EW-1:0] diag_s, up_s, left_s, m_s, mm_s, g_s;
  logic signed [EW-1:0] c_d, c_u, c_l, top;
  logic eq;

  always_comb begin
    eq     = (qch_i == dch_i) && (qch_i != PAD);
    diag_s = $signed({2'b00, diag_i});
    up_s   = $signed({2'b00, up_i});
    left_s = $signed({2'b00, left_i});
    m_s    = $signed({{(EW-PEN_W){1'b0}}, match_i});
    mm_s   = $signed({{(EW-PEN_W){1'b0}}, mismatch_i});
    g_s    = $signed({{(EW-PEN_W){1'b0}}, gap_i});
    c_d    = eq ? diag_s + m_s : diag_s - mm_s;
    c_u    = up_s - g_s;
    c_l    = left_s - g_s;
    top    = (c_d > c_u) ? c_d : c_u;
    if (c_l > top) top = c_l;
    h_o    = (top > 0) ? top[SCORE_W-1:0] : '0;
  end
endmodule

// File: rtl/lsa_pe.sv
module lsa_pe #(
  parameter int unsigned SCORE_W = lsa_pkg::SCORE_W_DEF,
  parameter int unsigned CHAR_W  = lsa_pkg::CHAR_W_DEF,
  parameter int unsigned PEN_W   = lsa_pkg::PEN_W_DEF,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned IDX     = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               qry_we_i,
  input  logic [IDX_W-1:0]   qry_idx_i,
  input  logic [CHAR_W-1:0]  qry_char_i,
  input  logic [PEN_W-1:0]   match_i,
  input  logic [PEN_W-1:0]   mismatch_i,
  input  logic [PEN_W-1:0]   gap_i,
  input  logic               vld_i,
  input  logic               first_i,
  input  logic               last_i,
  input  logic [CHAR_W-1:0]  dch_i,
  input  logic [SCORE_W-1:0] up_i,
  input  logic [SCORE_W-1:0] mx_i,
  output logic               vld_o,
  output logic               first_o,
  output logic               last_o,
  output logic [CHAR_W-1:0]  dch_o,
  output logic [SCORE_W-1:0] h_o,
  output logic [SCORE_W-1:0] mx_o
);
  logic [CHAR_W-1:0]  qch_q;
  logic [SCORE_W-1:0] diag_q, left_q, best_q;
  logic [SCORE_W-1:0] diag_e, left_e, base_e, h_new, own_best, mx_new;

  always_comb begin
    diag_e   = first_i ? '0 : diag_q;
    left_e   = first_i ? '0 : left_q;
    base_e   = first_i ? '0 : best_q;
    own_best = (base_e > h_new) ? base_e : h_new;
    mx_new   = (mx_i > own_best) ? mx_i : own_best;
  end

  lsa_cell #(.SCORE_W(SCORE_W), .CHAR_W(CHAR_W), .PEN_W(PEN_W)) u_cell (
    .qch_i(qch_q), .dch_i(dch_i), .diag_i(diag_e), .up_i(up_i), .left_i(left_e),
    .match_i(match_i), .mismatch_i(mismatch_i), .gap_i(gap_i), .h_o(h_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qch_q <= '1;
    end else if (qry_we_i && qry_idx_i == IDX_W'(IDX)) begin
      qch_q <= qry_char_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diag_q  <= '0;
      left_q  <= '0;
      best_q  <= '0;
      vld_o   <= 1'b0;
      first_o <= 1'b0;
      last_o  <= 1'b0;
      dch_o   <= '0;
      h_o     <= '0;
      mx_o    <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        diag_q  <= up_i;
        left_q  <= h_new;
        best_q  <= own_best;
        first_o <= first_i;
        last_o  <= last_i;
        dch_o   <= dch_i;
        h_o     <= h_new;
        mx_o    <= mx_new;
      end
    end
  end
endmodule

// File: rtl/lsa_array.sv
module lsa_array #(
  parameter int unsigned NUM_PE  = lsa_pkg::NUM_PE_DEF,
  parameter int unsigned SCORE_W = lsa_pkg::SCORE_W_DEF,
  parameter int unsigned CHAR_W  = lsa_pkg::CHAR_W_DEF,
  parameter int unsigned PEN_W   = lsa_pkg::PEN_W_DEF,
  localparam int unsigned IDX_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               qry_we_i,
  input  logic [IDX_W-1:0]   qry_idx_i,
  input  logic [CHAR_W-1:0]  qry_char_i,
  input  logic [PEN_W-1:0]   match_i,
  input  logic [PEN_W-1:0]   mismatch_i,
  input  logic [PEN_W-1:0]   gap_i,
  input  logic               in_valid_i,
  input  logic               in_first_i,
  input  logic               in_last_i,
  input  logic [CHAR_W-1:0]  in_char_i,
  output logic               out_valid_o,
  output logic               out_last_o,
  output logic [SCORE_W-1:0] best_o
);
  logic               vld_c   [NUM_PE+1];
  logic               first_c [NUM_PE+1];
  logic               last_c  [NUM_PE+1];
  logic [CHAR_W-1:0]  dch_c   [NUM_PE+1];
  logic [SCORE_W-1:0] h_c     [NUM_PE+1];
  logic [SCORE_W-1:0] mx_c    [NUM_PE+1];

  assign vld_c[0]   = in_valid_i;
  assign first_c[0] = in_first_i;
  assign last_c[0]  = in_last_i;
  assign dch_c[0]   = in_char_i;
  assign h_c[0]     = '0;  // row zero boundary
  assign mx_c[0]    = '0;

  for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
    lsa_pe #(
      .SCORE_W(SCORE_W), .CHAR_W(CHAR_W), .PEN_W(PEN_W), .IDX_W(IDX_W), .IDX(k)
    ) u_pe (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .qry_we_i(qry_we_i), .qry_idx_i(qry_idx_i), .qry_char_i(qry_char_i),
      .match_i(match_i), .mismatch_i(mismatch_i), .gap_i(gap_i),
      .vld_i(vld_c[k]), .first_i(first_c[k]), .last_i(last_c[k]),
      .dch_i(dch_c[k]), .up_i(h_c[k]), .mx_i(mx_c[k]),
      .vld_o(vld_c[k+1]), .first_o(first_c[k+1]), .last_o(last_c[k+1]),
      .dch_o(dch_c[k+1]), .h_o(h_c[k+1]), .mx_o(mx_c[k+1])
    );
  end

  assign out_valid_o = vld_c[NUM_PE];
  assign out_last_o  = vld_c[NUM_PE] & last_c[NUM_PE];
  assign best_o      = mx_c[NUM_PE];
endmodule

// File: rtl/lsa_array_chk.sv
module lsa_array_chk #(
  parameter int unsigned NUM_PE  = 48,
  parameter int unsigned SCORE_W = 24,
  parameter int unsigned IDX_W   = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               qry_we_i,
  input logic [IDX_W-1:0]   qry_idx_i,
  input logic               in_valid_i,
  input logic               out_valid_o,
  input logic [SCORE_W-1:0] best_o
);
  logic [31:0] n_in, n_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_in  <= '0;
      n_out <= '0;
    end else begin
      n_in  <= n_in + 32'(in_valid_i);
      n_out <= n_out + 32'(out_valid_o);
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_IDLE: assert (!out_valid_o && best_o == '0); // R6
    end
  end

  AST_QRY_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qry_we_i |-> (32'(qry_idx_i) < NUM_PE)); // R1

  AST_BEST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(best_o)); // R5

  AST_INFLIGHT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_out <= n_in) && ((n_in - n_out) <= NUM_PE)); // R8
endmodule

bind lsa_array lsa_array_chk #(
  .NUM_PE(NUM_PE), .SCORE_W(SCORE_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .qry_we_i(qry_we_i), .qry_idx_i(qry_idx_i),
  .in_valid_i(in_valid_i), .out_valid_o(out_valid_o), .best_o(best_o)
);

// File: tb/lsa_array_bench.sv
module lsa_array_bench;
  localparam int NP   = 8;
  localparam int SW   = 24;
  localparam int CW   = 5;
  localparam int PW   = 8;
  localparam int IW   = $clog2(NP);
  localparam int MAXL = 24;
  localparam int PAD  = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic qry_we = 1'b0;
  logic [IW-1:0] qry_idx = '0;
  logic [CW-1:0] qry_char = '0;
  logic [PW-1:0] mt = 8'd3, mm = 8'd1, gp = 8'd2;
  logic in_vld = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [CW-1:0] in_char = '0;
  logic out_vld, out_last;
  logic [SW-1:0] best;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int q [NP];
  int db [MAXL];
  int hm [NP+1][MAXL+1];
  int res_q [$];
  int n_out = 0;

  always #4 clk = ~clk;

  lsa_array #(.NUM_PE(NP), .SCORE_W(SW), .CHAR_W(CW), .PEN_W(PW)) u_lsa_array (
    .clk_i(clk), .rst_ni(rst_n), .qry_we_i(qry_we), .qry_idx_i(qry_idx),
    .qry_char_i(qry_char), .match_i(mt), .mismatch_i(mm), .gap_i(gp),
    .in_valid_i(in_vld), .in_first_i(in_first), .in_last_i(in_last),
    .in_char_i(in_char), .out_valid_o(out_vld), .out_last_o(out_last), .best_o(best)
  );

  always @(negedge clk) begin
    if (out_vld) n_out++;
    if (out_vld && out_last) res_q.push_back(int'(best));
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(int len);
    int b = 0;
    for (int i = 0; i <= NP; i++) hm[i][0] = 0;
    for (int j = 0; j <= len; j++) hm[0][j] = 0;
    for (int i = 1; i <= NP; i++)
      for (int j = 1; j <= len; j++) begin
        int s, v;
        s = (q[i-1] == db[j-1] && q[i-1] != PAD) ? int'(mt) : -int'(mm);
        v = 0;
        if (hm[i-1][j-1] + s > v) v = hm[i-1][j-1] + s;
        if (hm[i-1][j] - int'(gp) > v) v = hm[i-1][j] - int'(gp);
        if (hm[i][j-1] - int'(gp) > v) v = hm[i][j-1] - int'(gp);
        hm[i][j] = v;
        if (v > b) b = v;
      end
    return b;
  endfunction

  task automatic load_query();
    for (int k = 0; k < NP; k++) begin
      @(negedge clk);
      qry_we = 1'b1; qry_idx = IW'(k); qry_char = CW'(q[k]);
    end
    @(negedge clk);
    qry_we = 1'b0;
  endtask

  task automatic rand_pair(int qlen, int len);
    for (int k = 0; k < NP; k++) q[k] = (k < qlen) ? int'($urandom_range(0, 3)) : PAD;
    for (int j = 0; j < len; j++) db[j] = int'($urandom_range(0, 3));
  endtask

  // drive one sequence; the last symbol is driven on return
  task automatic drive_seq(int len, bit bubbles);
    for (int j = 0; j < len; j++) begin
      if (bubbles && ($urandom_range(0, 1) == 1)) begin
        @(negedge clk);
        in_vld = 1'b0; in_first = 1'b0; in_last = 1'b0;
      end
      @(negedge clk);
      in_vld = 1'b1; in_char = CW'(db[j]);
      in_first = (j == 0); in_last = (j == len - 1);
    end
  endtask

  task automatic idle_drain();
    @(negedge clk);
    in_vld = 1'b0; in_first = 1'b0; in_last = 1'b0;
    repeat (NP + 2) @(negedge clk);
  endtask

  task automatic run_one(string req, int len, bit bubbles);
    int exp;
    res_q.delete();
    exp = model(len);
    drive_seq(len, bubbles);
    idle_drain();
    check({req, " result count"}, res_q.size(), 1);
    if (res_q.size() > 0) check(req, res_q[0], exp);
  endtask

  task automatic t_reset();
    check("R6 out_valid in reset", int'(out_vld), 0);
    check("R6 best in reset", int'(best), 0);
  endtask

  task automatic t_index_write();
    for (int k = 0; k < NP; k++) q[k] = PAD;
    q[3] = 2;
    load_query();
    db[0] = 2;
    run_one("R1 stored symbol matches", 1, 1'b0);
    db[0] = 1;
    run_one("R1 other symbol no match", 1, 1'b0);
  endtask

  task automatic t_pad();
    for (int k = 0; k < NP; k++) q[k] = PAD;
    load_query();
    for (int j = 0; j < 6; j++) db[j] = PAD;
    run_one("R9 pad matches nothing", 6, 1'b0);
    check("R9 model pad score zero", model(6), 0);
  endtask

  task automatic t_random(int n);
    for (int t = 0; t < n; t++) begin
      rand_pair(int'($urandom_range(1, NP)), int'($urandom_range(1, MAXL)));
      load_query();
      run_one("R2 random pair", int'($urandom_range(1, MAXL)) % MAXL + 1, 1'b0);
    end
  endtask

  task automatic t_zero_floor();
    for (int k = 0; k < NP; k++) q[k] = k % 2;
    load_query();
    for (int j = 0; j < 12; j++) db[j] = 2 + (j % 2);
    run_one("R7 no shared symbol", 12, 1'b0);
  endtask

  task automatic t_bubbles();
    for (int t = 0; t < 3; t++) begin
      rand_pair(NP, MAXL);
      load_query();
      run_one("R5 idle cycles between symbols", MAXL, 1'b1);
    end
  endtask

  task automatic t_back_to_back();
    int ea, eb;
    res_q.delete();
    rand_pair(NP, 10);
    for (int k = 0; k < NP; k++) q[k] = k % 4;
    load_query();
    for (int j = 0; j < 10; j++) db[j] = j % 4;
    ea = model(10);
    drive_seq(10, 1'b0);
    for (int j = 0; j < 5; j++) db[j] = 3 - (j % 4);
    eb = model(5);
    drive_seq(5, 1'b0);
    idle_drain();
    check("R3 two results", res_q.size(), 2);
    if (res_q.size() == 2) begin
      check("R3 first sequence", res_q[0], ea);
      check("R3 second sequence independent", res_q[1], eb);
    end
  endtask

  task automatic t_latency_count();
    int cyc = 0, n0;
    rand_pair(NP, 7);
    load_query();
    n0 = n_out;
    drive_seq(7, 1'b0);
    @(negedge clk);
    in_vld = 1'b0; in_first = 1'b0; in_last = 1'b0;
    cyc = 1;
    while (!(out_vld && out_last) && cyc < 4 * NP) begin
      @(negedge clk);
      cyc++;
    end
    check("R4 last pulse latency", cyc, NP);
    repeat (NP + 2) @(negedge clk);
    check("R8 one output per symbol", n_out - n0, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_index_write();
    t_pad();
    t_random(6);
    mt = 8'd5; mm = 8'd4; gp = 8'd1;
    t_random(4);
    mt = 8'd2; mm = 8'd1; gp = 8'd1;
    t_zero_floor();
    t_bubbles();
    t_back_to_back();
    t_latency_count();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule